// File: doc/BRIEF.md
# Internal Bus Ownership Arbiter

This block decides which of three on-chip masters drives a shared system bus: one serial-channel DMA engine and two block-move DMA engines (A and B). Software gives each master an arbitration ID in a configuration register. The requester with the largest non-zero ID wins the bus. Once a master owns the bus it keeps it until a bus cycle ends. If the serial engine outranks a block-move engine that owns the bus, it takes over at the next cycle boundary, with no idle or handshake cycle in between.

The block also drives a bus-clear output toward external masters. This output is raised only when the serial engine's ID is strictly above a programmable threshold, and it drops as the serial engine enters its final bus cycle. When the host CPU is disabled (slave mode), the arbiter requests the external bus itself and waits for the external grant before handing out the first internal grant. When the host CPU is enabled, the external request and acknowledge lines are left alone. A status register records which master owned the bus when a bus error was reported.

Top module: `sysbus_arbiter`

## Requirements
- R1: The 16-bit configuration register resets to 0. It is written at address 0 only when `reg_super_i` is high. The fields are: serial ID in bits [2:0], engine A ID in bits [5:3], engine B ID in bits [8:6], and bus-clear threshold in bits [11:9]. A read with `reg_rd_i` returns the addressed register on `reg_rdata_o` one cycle later if `reg_super_i` is high, and returns 0 otherwise.
- R2: From idle, `gnt_o` becomes one-hot one cycle after the requests are sampled. It selects the requester with the largest ID. Equal IDs are resolved serial first (bit 0), then engine A (bit 1), then engine B (bit 2).
- R3: A master whose ID is 0 is never granted. If no valid request is present, `gnt_o` stays 0.
- R4: While a master owns the bus, `gnt_o` stays unchanged in every cycle where `cyc_end_i` is low. When `cyc_end_i` is high together with the owner's `last_i` bit, the bus goes to the current winner, or to idle if there is none.
- R5: If a block-move engine owns the bus and the serial engine wins on ID, `gnt_o` moves straight to the serial engine on the edge that samples `cyc_end_i`. The owner's `last_i` is not needed for this. A serial engine with a lower ID does not take the bus, and the two block-move engines never take the bus from each other.
- R6: `bus_clr_o` goes high one cycle after the serial engine requests, but only when its ID is strictly greater than the threshold. An equal ID keeps it low.
- R7: `bus_clr_o` goes low on the edge that samples the serial owner's `last_i[0]`, while the serial engine still holds the grant.
- R8: With `host_en_i` high, `ext_br_o` and `ext_bgack_o` stay low, and grants do not wait for `ext_bg_i`.
- R9: With `host_en_i` low, `ext_br_o` goes high one cycle after a valid request appears. A grant from idle is issued only on an edge where `ext_bg_i` is high. `ext_bgack_o` is high while any master owns the bus, and cycle stealing by the serial engine works as in R5.
- R10: When `bus_err_i` is sampled while the bus is owned, the status register at address 1 records the owner index in bits [1:0] (0 = serial, 1 = engine A, 2 = engine B) and sets bit 2. Later errors leave the record unchanged until a supervisor write at address 1 with bit 2 set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en_i | input | 1 | Host CPU enabled (0 = slave mode) |
| req_i | input | 3 | Bus requests: bit 0 serial, bit 1 engine A, bit 2 engine B |
| last_i | input | 3 | Final-cycle indication per master |
| cyc_end_i | input | 1 | Current bus cycle ends this clock |
| gnt_o | output | 3 | One-hot bus grant |
| bus_clr_o | output | 1 | Bus-clear request to external masters |
| ext_br_o | output | 1 | External bus request (slave mode) |
| ext_bg_i | input | 1 | External bus grant |
| ext_bgack_o | output | 1 | External bus grant acknowledge (slave mode) |
| bus_err_i | input | 1 | Bus error on the current cycle |
| reg_addr_i | input | 1 | Register select: 0 config, 1 status |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_super_i | input | 1 | Access is in supervisor mode |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |

## Verification
The assertions assume that an owning master keeps `cyc_end_i` low except at real cycle boundaries. They also assume that the configuration is not rewritten in the same cycle a grant is decided, because the ID checks look at the configuration as it stood on the deciding edge. The stimulus changes inputs only on falling edges, rewrites the configuration only while the bus is idle, and raises `cyc_end_i` only for deliberate release or steal steps. Every sequence ends by releasing the bus with `last_i` and `cyc_end_i`, so each vector starts from idle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_MST = 3;
  localparam int CODE_W  = 2;

  function automatic logic [CODE_W-1:0] owner_code(input logic [NUM_MST-1:0] oh);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int k = 0; k < NUM_MST; k++) begin
      if (oh[k]) c = CODE_W'(k);
    end
    return c;
  endfunction
endpackage

// File: rtl/arb_pick.sv
// Largest-ID selector; strict compare gives lower index the win on ties,
// and a zero ID can never beat the initial best of zero.
module arb_pick #(
  parameter int N    = 3,
  parameter int ID_W = 3
) (
  input  logic [N-1:0]      req_i,
  input  logic [N*ID_W-1:0] ids_i,
  output logic [N-1:0]      win_o
);
  logic [ID_W-1:0] best;

  always_comb begin
    best  = '0;
    win_o = '0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && (ids_i[k*ID_W +: ID_W] > best)) begin
        best     = ids_i[k*ID_W +: ID_W];
        win_o    = '0;
        win_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_regs.sv
module arb_regs #(
  parameter int REG_W  = 16,
  parameter int N      = 3,
  parameter int CODE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic             reg_super_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             err_i,
  input  logic [N-1:0]     owner_i,
  output logic [REG_W-1:0] cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int VLD_BIT = CODE_W;

  logic              err_vld;
  logic [CODE_W-1:0] err_code;
  logic              wr_ok, clr_err;

  assign wr_ok   = reg_wr_i && reg_super_i;
  assign clr_err = wr_ok && reg_addr_i && reg_wdata_i[VLD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o    <= '0;
      err_vld  <= 1'b0;
      err_code <= '0;
      rdata_o  <= '0;
    end else begin
      if (wr_ok && !reg_addr_i) cfg_o <= reg_wdata_i;
      if (clr_err) begin
        err_vld  <= 1'b0;
        err_code <= '0;
      end else if (err_i && (|owner_i) && !err_vld) begin
        err_vld  <= 1'b1;
        err_code <= arb_pkg::owner_code(owner_i);
      end
      if (reg_rd_i && reg_super_i)
        rdata_o <= reg_addr_i ? REG_W'({err_vld, err_code}) : cfg_o;
      else
        rdata_o <= '0;
    end
  end
endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter #(
  parameter int ID_W  = 3,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_en_i,
  input  logic [2:0]       req_i,
  input  logic [2:0]       last_i,
  input  logic             cyc_end_i,
  output logic [2:0]       gnt_o,
  output logic             bus_clr_o,
  output logic             ext_br_o,
  input  logic             ext_bg_i,
  output logic             ext_bgack_o,
  input  logic             bus_err_i,
  input  logic             reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic             reg_super_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o
);
  import arb_pkg::*;

  localparam int THR_LSB = NUM_MST * ID_W;

  logic [REG_W-1:0]        cfg_q;
  logic [NUM_MST*ID_W-1:0] ids;
  logic [ID_W-1:0]         ser_id, thr;
  logic [NUM_MST-1:0]      win, gnt_d;
  logic                    owned, owner_last, may_start, clr_d;

  genvar g;
  generate
    for (g = 0; g < NUM_MST; g++) begin : g_ids
      assign ids[g*ID_W +: ID_W] = cfg_q[g*ID_W +: ID_W];
    end
  endgenerate

  assign ser_id = ids[0 +: ID_W];
  assign thr    = cfg_q[THR_LSB +: ID_W];

  arb_regs #(.REG_W(REG_W), .N(NUM_MST), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_rd_i(reg_rd_i), .reg_super_i(reg_super_i), .reg_wdata_i(reg_wdata_i),
    .err_i(bus_err_i), .owner_i(gnt_o), .cfg_o(cfg_q), .rdata_o(reg_rdata_o)
  );

  arb_pick #(.N(NUM_MST), .ID_W(ID_W)) u_pick (
    .req_i(req_i), .ids_i(ids), .win_o(win)
  );

  assign owned      = |gnt_o;
  assign owner_last = |(gnt_o & last_i);
  assign may_start  = host_en_i || ext_bg_i;

  always_comb begin
    gnt_d = gnt_o;
    if (!owned) begin
      if ((|win) && may_start) gnt_d = win;
    end else if (cyc_end_i) begin
      if (owner_last)             gnt_d = win;
      else if (win[0] && !gnt_o[0]) gnt_d = win;   // serial steals a cycle
    end
  end

  assign clr_d = req_i[0] && (ser_id > thr) && !(gnt_o[0] && last_i[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o       <= '0;
      bus_clr_o   <= 1'b0;
      ext_br_o    <= 1'b0;
      ext_bgack_o <= 1'b0;
    end else begin
      gnt_o       <= gnt_d;
      bus_clr_o   <= clr_d;
      ext_br_o    <= !host_en_i && (|win);
      ext_bgack_o <= !host_en_i && (|gnt_d);
    end
  end
endmodule

// File: rtl/sysbus_arbiter_chk.sv
module sysbus_arbiter_chk #(
  parameter int ID_W  = 3,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             host_en_i,
  input logic [2:0]       last_i,
  input logic             cyc_end_i,
  input logic             ext_bg_i,
  input logic [2:0]       gnt_o,
  input logic             bus_clr_o,
  input logic             ext_br_o,
  input logic             ext_bgack_o,
  input logic [REG_W-1:0] cfg
);
  logic [ID_W-1:0] s_id, a_id, b_id, th;
  assign s_id = cfg[0 +: ID_W];
  assign a_id = cfg[ID_W +: ID_W];
  assign b_id = cfg[2*ID_W +: ID_W];
  assign th   = cfg[3*ID_W +: ID_W];

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((|gnt_o) && !cyc_end_i) |=> $stable(gnt_o));

  p_zero_ser_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_o[0]) |-> ($past(s_id) != '0));
  p_zero_a_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_o[1]) |-> ($past(a_id) != '0));
  p_zero_b_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gnt_o[2]) |-> ($past(b_id) != '0));

  p_clr_strict_r6: assert property (@(posedge clk) disable iff (rst)
    bus_clr_o |-> $past(s_id > th));

  p_clr_final_r7: assert property (@(posedge clk) disable iff (rst)
    (gnt_o[0] && last_i[0]) |=> !bus_clr_o);

  p_host_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    host_en_i |=> (!ext_br_o && !ext_bgack_o));

  p_slave_wait_r9: assert property (@(posedge clk) disable iff (rst)
    ((gnt_o == 3'b000) && !host_en_i && !ext_bg_i) |=> (gnt_o == 3'b000));
endmodule

bind sysbus_arbiter sysbus_arbiter_chk #(.ID_W(ID_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .host_en_i(host_en_i), .last_i(last_i),
  .cyc_end_i(cyc_end_i), .ext_bg_i(ext_bg_i), .gnt_o(gnt_o),
  .bus_clr_o(bus_clr_o), .ext_br_o(ext_br_o), .ext_bgack_o(ext_bgack_o),
  .cfg(cfg_q)
);

// File: tb/sysbus_arbiter_bench.sv
`timescale 1ns/1ps
module sysbus_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {serial id, A id, B id, requests, expected grant}
  localparam logic [14:0] VEC [NV] = '{
    {3'd3, 3'd2, 3'd1, 3'b111, 3'b001},
    {3'd1, 3'd5, 3'd2, 3'b111, 3'b010},
    {3'd1, 3'd2, 3'd6, 3'b111, 3'b100},
    {3'd4, 3'd4, 3'd4, 3'b111, 3'b001},
    {3'd0, 3'd4, 3'd4, 3'b111, 3'b010},
    {3'd2, 3'd3, 3'd3, 3'b110, 3'b010},
    {3'd0, 3'd0, 3'd0, 3'b111, 3'b000},
    {3'd7, 3'd0, 3'd5, 3'b101, 3'b001}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic host_en = 1'b1, cyc_end = 1'b0, ext_bg = 1'b0, bus_err = 1'b0;
  logic [2:0] req = '0, last = '0, gnt;
  logic bus_clr, ext_br, ext_bgack;
  logic reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, reg_super = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysbus_arbiter u_sysbus_arbiter (
    .clk(clk), .rst(rst), .host_en_i(host_en), .req_i(req), .last_i(last),
    .cyc_end_i(cyc_end), .gnt_o(gnt), .bus_clr_o(bus_clr), .ext_br_o(ext_br),
    .ext_bg_i(ext_bg), .ext_bgack_o(ext_bgack), .bus_err_i(bus_err),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_super_i(reg_super), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [15:0] cfgw(input logic [2:0] s, a, b, t);
    return {4'b0, t, b, a, s};
  endfunction

  task automatic wr_reg(input logic a, input logic [15:0] d, input logic sup);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_super = sup;
    step();
    reg_wr = 1'b0; reg_super = 1'b0;
  endtask

  task automatic rd_reg(input logic a, input logic sup, output logic [15:0] v);
    reg_addr = a; reg_rd = 1'b1; reg_super = sup;
    step();
    v = reg_rdata;
    reg_rd = 1'b0; reg_super = 1'b0;
  endtask

  task automatic release_all();
    req = '0; last = 3'b111; cyc_end = 1'b1;
    step();
    last = '0; cyc_end = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) step();
    rst = 1'b0;
    step();
    // reset state
    chk("R1 reset grant", 16'(gnt), 16'h0);
    chk("R6 reset bus_clr", 16'(bus_clr), 16'h0);
    chk("R8 reset ext_br", 16'(ext_br), 16'h0);
    rd_reg(1'b0, 1'b1, v);
    chk("R1 config reset value", v, 16'h0);

    // register access rules
    wr_reg(1'b0, 16'h0ABC, 1'b1);
    rd_reg(1'b0, 1'b1, v);
    chk("R1 supervisor write/read", v, 16'h0ABC);
    wr_reg(1'b0, 16'h1234, 1'b0);
    rd_reg(1'b0, 1'b1, v);
    chk("R1 user write ignored", v, 16'h0ABC);
    rd_reg(1'b0, 1'b0, v);
    chk("R1 user read returns zero", v, 16'h0);

    // table walk: arbitration from idle
    for (int i = 0; i < NV; i++) begin
      wr_reg(1'b0, cfgw(VEC[i][14:12], VEC[i][11:9], VEC[i][8:6], 3'd7), 1'b1);
      req = VEC[i][5:3];
      step();
      if (VEC[i][2:0] == 3'b000)
        chk($sformatf("R3 vector %0d zero IDs not granted", i), 16'(gnt), 16'h0);
      else
        chk($sformatf("R2 vector %0d winner", i), 16'(gnt), 16'(VEC[i][2:0]));
      release_all();
      chk($sformatf("R4 vector %0d release to idle", i), 16'(gnt), 16'h0);
    end

    // serial steal from engine A
    wr_reg(1'b0, cfgw(3'd5, 3'd3, 3'd1, 3'd7), 1'b1);
    req = 3'b010; step();
    chk("R2 engine A owns", 16'(gnt), 16'h2);
    req = 3'b011; step();
    chk("R4 no change without cycle end", 16'(gnt), 16'h2);
    cyc_end = 1'b1; step(); cyc_end = 1'b0;
    chk("R5 serial steals at cycle end", 16'(gnt), 16'h1);
    req = 3'b010; last = 3'b001; cyc_end = 1'b1; step();
    last = '0; cyc_end = 1'b0;
    chk("R4 bus returns to engine A", 16'(gnt), 16'h2);
    release_all();

    // engines do not preempt each other
    wr_reg(1'b0, cfgw(3'd1, 3'd6, 3'd2, 3'd7), 1'b1);
    req = 3'b100; step();
    req = 3'b110; cyc_end = 1'b1; step(); cyc_end = 1'b0;
    chk("R5 engine A does not preempt B", 16'(gnt), 16'h4);
    release_all();
    // lower-ID serial does not steal
    req = 3'b010; step();
    req = 3'b011; cyc_end = 1'b1; step(); cyc_end = 1'b0;
    chk("R5 lower serial ID no steal", 16'(gnt), 16'h2);
    release_all();

    // host enabled: external lines quiet
    wr_reg(1'b0, cfgw(3'd5, 3'd3, 3'd1, 3'd7), 1'b1);
    req = 3'b010; step();
    chk("R8 grant without ext grant", 16'(gnt), 16'h2);
    chk("R8 ext_br low", 16'(ext_br), 16'h0);
    chk("R8 ext_bgack low", 16'(ext_bgack), 16'h0);
    release_all();

    // slave mode
    host_en = 1'b0; ext_bg = 1'b0;
    req = 3'b010; step();
    chk("R9 ext_br raised", 16'(ext_br), 16'h1);
    chk("R9 grant waits for ext grant", 16'(gnt), 16'h0);
    ext_bg = 1'b1; step();
    chk("R9 grant after ext grant", 16'(gnt), 16'h2);
    chk("R9 ext_bgack high", 16'(ext_bgack), 16'h1);
    ext_bg = 1'b0;
    req = 3'b011; cyc_end = 1'b1; step(); cyc_end = 1'b0;
    chk("R9 steal in slave mode", 16'(gnt), 16'h1);
    chk("R9 ext_bgack held over steal", 16'(ext_bgack), 16'h1);
    release_all();
    chk("R9 ext_bgack drops at release", 16'(ext_bgack), 16'h0);
    host_en = 1'b1;
    step();

    // bus clear
    wr_reg(1'b0, cfgw(3'd5, 3'd3, 3'd1, 3'd3), 1'b1);
    req = 3'b001; step();
    chk("R6 bus_clr raised id>threshold", 16'(bus_clr), 16'h1);
    last = 3'b001; step();
    chk("R7 bus_clr drops in final cycle", 16'(bus_clr), 16'h0);
    chk("R7 serial still owns in final cycle", 16'(gnt), 16'h1);
    release_all();
    wr_reg(1'b0, cfgw(3'd5, 3'd3, 3'd1, 3'd5), 1'b1);
    req = 3'b001; step();
    chk("R6 bus_clr low when id equals threshold", 16'(bus_clr), 16'h0);
    release_all();

    // bus error status
    wr_reg(1'b0, cfgw(3'd1, 3'd3, 3'd2, 3'd7), 1'b1);
    req = 3'b010; step();
    bus_err = 1'b1; step(); bus_err = 1'b0;
    release_all();
    rd_reg(1'b1, 1'b1, v);
    chk("R10 error records engine A", v, 16'h0005);
    req = 3'b100; step();
    bus_err = 1'b1; step(); bus_err = 1'b0;
    release_all();
    rd_reg(1'b1, 1'b1, v);
    chk("R10 first error kept", v, 16'h0005);
    wr_reg(1'b1, 16'h0004, 1'b0);
    rd_reg(1'b1, 1'b1, v);
    chk("R10 user clear ignored", v, 16'h0005);
    wr_reg(1'b1, 16'h0004, 1'b1);
    rd_reg(1'b1, 1'b1, v);
    chk("R10 supervisor clear", v, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule